// File: doc/BRIEF.md
# Bus Controller Status and Command Register

This block is the 32-bit configuration word that a PCI-style bus controller exposes to host software. The low half holds the command enables that steer the bus engine: I/O and memory decode, bus mastering, memory-write-and-invalidate, parity response, SERR# reporting and fast back-to-back. The high half holds read-only capability constants and a set of sticky error flags.

The bus protocol engine drives one-cycle event pulses. Each pulse may be qualified by the controller's role or by the transaction type, and a qualified pulse raises its flag. A flag stays raised until software writes a one to its bit. Software accesses the word through a plain read/write port with four byte enables. A role input marks the controller as a non-host agent. While it is high, software access is blocked, but the bus engine can still record events.

Top module: `cfg_status_command`

## Requirements
- R1: After a synchronous active-low reset, every flag and every command enable is 0, and a read returns 0x02B0_0000 with the default capability parameters.
- R2: A write changes only the byte lanes whose enable is set. Lane 0 covers bits 7:0, lane 1 covers bits 15:8 and lane 3 covers bits 31:24. Lane 2 holds only constants.
- R3: Command bits 0 (I/O decode), 1 (memory decode), 2 (bus master), 4 (memory-write-and-invalidate), 6 (parity response), 8 (SERR# enable) and 9 (fast back-to-back enable) are read/write. Bits 3, 5, 7 and 15:10 always read 0.
- R4: Flags at bits 31, 30, 29, 28, 27 and 24 are sticky. Writing 1 clears a flag and writing 0 leaves it unchanged.
- R5: Bit 31 (parity error seen) sets on any of three events: a data parity error as read initiator, a data parity error as write target, or an address parity error. The parity-response enable has no effect on it.
- R6: Bit 30 (system error raised) sets on an address parity error or a special-cycle data parity error, but only while command bit 8 is 1.
- R7: Bit 29 (master abort received) sets when an initiated transaction ends in master abort, unless that transaction is a special cycle.
- R8: Bit 28 sets on a target abort received as initiator. Bit 27 sets when the controller ends a transaction as target with a target abort.
- R9: Bit 24 (initiator data parity) sets on a read-initiator data parity error, or when a target reports a parity error on the controller's write. It sets only while command bit 6 is 1.
- R10: Bits 26:25 read 01 (medium decode speed; 00 fast, 10 slow, 11 reserved). Bits 23, 21 and 20 read their capability parameters. Bits 22 and 19:16 read 0. Writes change none of these.
- R11: While `agent_mode` is 1, reads return 0 and writes change nothing. Event pulses still set flags, and the flags are visible once `agent_mode` returns to 0.
- R12: If an event pulse and a write of 1 hit the same flag in the same cycle, the flag ends set.
- R13: `reg_rdata` is 0 whenever `reg_rd_en` is 0, and it shows the current word in the same cycle that `reg_rd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| agent_mode | input | 1 | 1 = non-host role, software access blocked |
| reg_wr_en | input | 1 | Software write strobe |
| reg_rd_en | input | 1 | Software read strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| ev_rd_init_data_perr | input | 1 | Data parity error as read initiator |
| ev_wr_tgt_data_perr | input | 1 | Data parity error as write target |
| ev_addr_perr | input | 1 | Address parity error |
| ev_special_data_perr | input | 1 | Data parity error in a special cycle |
| ev_wr_init_perr_reported | input | 1 | Target reported parity error on own write |
| ev_master_abort | input | 1 | Initiated transaction ended in master abort |
| ev_special_cycle | input | 1 | Current transaction is a special cycle |
| ev_target_abort_rcvd | input | 1 | Target abort received as initiator |
| ev_target_abort_sent | input | 1 | Target abort issued as target |
| cmd_q | output | 16 | Current command enables for the bus engine |

## Verification
The hardest state to reach is an event and a clearing write landing on the same flag in the same cycle, across every mix of events. The bench drives every one of the 512 event patterns together with an all-ones clear of the flag byte. The enable-qualified flags depend on the command word that is current at the moment of the pulse, so every event pattern is also swept under all four settings of the SERR# and parity-response enables. Each flag is cleared before every pulse so that each result shows the effect of that single cycle.

// File: rtl/scr_pkg.sv
// Shared constants for the status/command register.
// Assumes flag index order is fixed by the read-word assembly in the top.
package scr_pkg;
    localparam int NUM_FLAGS = 6;
    localparam int FL_MDPE   = 0;   // word bit 24
    localparam int FL_STA    = 1;   // word bit 27
    localparam int FL_RTA    = 2;   // word bit 28
    localparam int FL_RMA    = 3;   // word bit 29
    localparam int FL_SSE    = 4;   // word bit 30
    localparam int FL_DPE    = 5;   // word bit 31

    localparam int CMD_W       = 16;
    localparam int BIT_PRESP   = 6;
    localparam int BIT_SERR_EN = 8;
    localparam logic [CMD_W-1:0] CMD_RW_MASK   = 16'h0357;
    localparam logic [1:0]       DEVSEL_MEDIUM = 2'b01;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/scr_event_decode.sv
// Turns bus-engine event pulses into per-flag set requests.
// Assumes pulses are one cycle wide and enables are the registered command bits.
module scr_event_decode
    import scr_pkg::*;
(
    input  logic      rd_init_data_perr,
    input  logic      wr_tgt_data_perr,
    input  logic      addr_perr,
    input  logic      special_data_perr,
    input  logic      wr_init_perr_reported,
    input  logic      master_abort,
    input  logic      special_cycle,
    input  logic      target_abort_rcvd,
    input  logic      target_abort_sent,
    input  logic      perr_resp_en,
    input  logic      serr_en,
    output flag_vec_t set_o
);
    // Qualify each event by role, transaction type and enable.
    always_comb begin
        set_o          = '0;
        set_o[FL_DPE]  = rd_init_data_perr | wr_tgt_data_perr | addr_perr;
        set_o[FL_SSE]  = serr_en & (addr_perr | special_data_perr);
        set_o[FL_RMA]  = master_abort & ~special_cycle;
        set_o[FL_RTA]  = target_abort_rcvd;
        set_o[FL_STA]  = target_abort_sent;
        set_o[FL_MDPE] = perr_resp_en & (rd_init_data_perr | wr_init_perr_reported);
    end
endmodule

// File: rtl/scr_flag_bank.sv
// Bank of sticky flags, each set by an event and cleared by a write of 1.
// Assumes set and clear arrive already qualified; set beats clear.
module scr_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold, clear or set one flag; a set in the same cycle wins.
        always_ff @(posedge clk) begin
            if (!rst_n)        flags_o[i] <= 1'b0;
            else if (set_i[i]) flags_o[i] <= 1'b1;
            else if (clr_i[i]) flags_o[i] <= 1'b0;
        end

        a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        a_r4_clear_on_one: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] && !set_i[i] |=> !flags_o[i]);
        a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            flags_o[i] && !clr_i[i] |=> flags_o[i]);
    end
endmodule

// File: rtl/scr_cmd_bank.sv
// Command-enable storage with byte-lane writes; only masked bits exist.
// Assumes the write strobe is already gated by the access mode.
module scr_cmd_bank #(
    parameter int               W       = 16,
    parameter logic [W-1:0]     RW_MASK = 16'h0357,
    localparam int              LANES   = W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [LANES-1:0] be_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     cmd_o
);
    logic [W-1:0] unused_wd_bits;
    assign unused_wd_bits = wdata_i & ~RW_MASK;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (RW_MASK[b]) begin : g_rw
            // Load this bit when its lane is enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)                 cmd_o[b] <= 1'b0;
                else if (wr_i && be_i[b/8]) cmd_o[b] <= wdata_i[b];
            end
        end else begin : g_zero
            assign cmd_o[b] = 1'b0;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && be_i[l]) |=> $stable(cmd_o[l*8 +: 8]));
    end
endmodule

// File: rtl/cfg_status_command.sv
// 32-bit status/command configuration word for a bus controller.
// Upper half: sticky error flags and read-only capabilities; lower half: enables.
// Assumes single-cycle event pulses and a combinational read port.
module cfg_status_command
    import scr_pkg::*;
#(
    parameter bit CAP_FAST_B2B = 1'b1,
    parameter bit CAP_66MHZ    = 1'b1,
    parameter bit CAP_LIST     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        agent_mode,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ev_rd_init_data_perr,
    input  logic        ev_wr_tgt_data_perr,
    input  logic        ev_addr_perr,
    input  logic        ev_special_data_perr,
    input  logic        ev_wr_init_perr_reported,
    input  logic        ev_master_abort,
    input  logic        ev_special_cycle,
    input  logic        ev_target_abort_rcvd,
    input  logic        ev_target_abort_sent,
    output logic [15:0] cmd_q
);
    logic      host_wr;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags_q;
    logic      unused_wd;
    logic [31:0] word;

    assign host_wr   = reg_wr_en && !agent_mode;
    assign unused_wd = ^{reg_wdata[26:25], reg_wdata[23:16], reg_be[2]};

    // Write-one-to-clear requests from the top byte lane.
    always_comb begin
        clr_vec = '0;
        if (host_wr && reg_be[3]) clr_vec = {reg_wdata[31:27], reg_wdata[24]};
    end

    scr_event_decode i_decode (
        .rd_init_data_perr     (ev_rd_init_data_perr),
        .wr_tgt_data_perr      (ev_wr_tgt_data_perr),
        .addr_perr             (ev_addr_perr),
        .special_data_perr     (ev_special_data_perr),
        .wr_init_perr_reported (ev_wr_init_perr_reported),
        .master_abort          (ev_master_abort),
        .special_cycle         (ev_special_cycle),
        .target_abort_rcvd     (ev_target_abort_rcvd),
        .target_abort_sent     (ev_target_abort_sent),
        .perr_resp_en          (cmd_q[BIT_PRESP]),
        .serr_en               (cmd_q[BIT_SERR_EN]),
        .set_o                 (set_vec)
    );

    scr_flag_bank #(.N(NUM_FLAGS)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags_q)
    );

    scr_cmd_bank #(.W(CMD_W), .RW_MASK(CMD_RW_MASK)) i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (host_wr),
        .be_i    (reg_be[1:0]),
        .wdata_i (reg_wdata[15:0]),
        .cmd_o   (cmd_q)
    );

    // Assemble the visible word and gate it by strobe and access mode.
    always_comb begin
        word = {flags_q[FL_DPE], flags_q[FL_SSE], flags_q[FL_RMA],
                flags_q[FL_RTA], flags_q[FL_STA], DEVSEL_MEDIUM,
                flags_q[FL_MDPE], CAP_FAST_B2B, 1'b0, CAP_66MHZ,
                CAP_LIST, 4'b0000, cmd_q};
        reg_rdata = (reg_rd_en && !agent_mode) ? word : 32'h0;
    end

    a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        agent_mode && reg_wr_en |=> $stable(cmd_q));
    a_r5_addr_perr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_perr |=> flags_q[FL_DPE]);
    a_r6_sse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q[BIT_SERR_EN] && !flags_q[FL_SSE] |=> !flags_q[FL_SSE]);
    a_r7_special_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        ev_special_cycle && !ev_master_abort ? 1'b0 :
        (ev_master_abort && ev_special_cycle && !flags_q[FL_RMA]) |=> !flags_q[FL_RMA]);
    a_r9_mdpe_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q[BIT_PRESP] && !flags_q[FL_MDPE] |=> !flags_q[FL_MDPE]);
    a_r8_target_abort_sent: assert property (@(posedge clk) disable iff (!rst_n)
        ev_target_abort_sent |=> flags_q[FL_STA]);
endmodule

// File: tb/test_cfg_status_command.sv
module test_cfg_status_command;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        agent_mode = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  ev = '0;
    logic [15:0] cmd_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] exp_cmd;
    logic [5:0]  exp_f;   // {dpe,sse,rma,rta,sta,mdpe}

    always #2 clk = ~clk;   // 250 MHz

    cfg_status_command i_cfg_status_command (
        .clk(clk), .rst_n(rst_n), .agent_mode(agent_mode),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_rd_init_data_perr(ev[0]), .ev_wr_tgt_data_perr(ev[1]),
        .ev_addr_perr(ev[2]), .ev_special_data_perr(ev[3]),
        .ev_wr_init_perr_reported(ev[4]), .ev_master_abort(ev[5]),
        .ev_special_cycle(ev[6]), .ev_target_abort_rcvd(ev[7]),
        .ev_target_abort_sent(ev[8]), .cmd_q(cmd_q)
    );

    function automatic logic [5:0] exp_set(input logic [8:0] e, input logic [15:0] c);
        logic [5:0] s;
        s[5] = e[0] | e[1] | e[2];                 // R5
        s[4] = c[8] & (e[2] | e[3]);               // R6
        s[3] = e[5] & ~e[6];                       // R7
        s[2] = e[7];                               // R8
        s[1] = e[8];                               // R8
        s[0] = c[6] & (e[0] | e[4]);               // R9
        return s;
    endfunction

    function automatic logic [31:0] exp_word();
        return {exp_f[5:1], 2'b01, exp_f[0], 1'b1, 1'b0, 1'b1, 1'b1, 4'b0, exp_cmd};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One clock cycle of stimulus, then update the model.
    task automatic step(input bit wr, input logic [3:0] be, input logic [31:0] wd,
                        input logic [8:0] e);
        logic [5:0] s;
        logic [5:0] c;
        @(negedge clk);
        reg_wr_en = wr; reg_be = be; reg_wdata = wd; ev = e;
        @(posedge clk);
        #1;
        reg_wr_en = 0; reg_be = '0; reg_wdata = '0; ev = '0;
        s = exp_set(e, exp_cmd);
        c = (wr && !agent_mode && be[3]) ? {wd[31:27], wd[24]} : 6'h0;
        exp_f = (exp_f & ~c) | s;                  // R12: set beats clear
        if (wr && !agent_mode) begin
            if (be[0]) exp_cmd[7:0]  = wd[7:0]  & 8'h57;
            if (be[1]) exp_cmd[15:8] = wd[15:8] & 8'h03;
        end
    endtask

    task automatic read_check(input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1;
        #1;
        check(tag, reg_rdata, agent_mode ? 32'h0 : exp_word());
        reg_rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        exp_cmd = '0; exp_f = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        read_check("R1 reset value");
        check("R1 reset command", {16'h0, cmd_q}, 32'h0);
        @(negedge clk); #1;
        check("R13 idle read data", reg_rdata, 32'h0);

        // R3 and R10: write all ones everywhere.
        step(1, 4'hF, 32'hFFFF_FFFF, 9'h0);
        read_check("R3/R10 all-ones write");
        check("R3 cmd_q", {16'h0, cmd_q}, 32'h0000_0357);

        // R2/R4: byte-lane sweep with all flags raised.
        for (int b = 0; b < 16; b++) begin
            step(1, 4'hF, 32'h0000_0357, 9'h0);
            step(0, 4'h0, 32'h0, 9'h1FF);
            step(1, 4'(b), 32'hFFFF_FFFF, 9'h0);
            read_check("R2/R4 lane ones");
            step(1, 4'hF, 32'h0000_0000, 9'h0);
            read_check("R4 zero write keeps flags");
        end

        // R5..R9: every event pattern under every enable pair.
        for (int e = 0; e < 512; e++) begin
            for (int en = 0; en < 4; en++) begin
                step(1, 4'b0011, {16'h0, 7'h0, en[1], 1'b0, en[0], 6'h0}, 9'h0);
                step(1, 4'b1000, 32'hFF00_0000, 9'h0);
                step(0, 4'h0, 32'h0, 9'(e));
                read_check("R5/R6/R7/R8/R9 event sweep");
            end
        end

        // R12: each event pattern together with an all-ones clear.
        step(1, 4'b0011, 32'h0000_0357, 9'h0);
        for (int e = 0; e < 512; e++) begin
            step(0, 4'h0, 32'h0, 9'h1FF);
            step(1, 4'b1000, 32'hFF00_0000, 9'(e));
            read_check("R12 set beats clear");
        end

        // R11: agent mode blocks access but not events.
        step(1, 4'hF, 32'hFF00_0000, 9'h0);
        agent_mode = 1'b1;
        step(1, 4'hF, 32'hFFFF_FFFF, 9'h0);
        read_check("R11 read blocked");
        step(0, 4'h0, 32'h0, 9'h1FF);
        step(1, 4'hF, 32'hFF00_0000, 9'h0);
        read_check("R11 read blocked after events");
        agent_mode = 1'b0;
        read_check("R11 events kept, writes ignored");
        check("R11 cmd unchanged", {16'h0, cmd_q}, {16'h0, exp_cmd});

        finish_run();
    end
endmodule